// File: doc/BRIEF.md
# Multi-Mode Self-Test Observer Register

This block is a WIDTH-bit register that can stand in for an ordinary pipeline register. It also serves as a built-in self-test element. Three control inputs set its mode:

- It can capture its parallel data word, as a normal register would.
- It can clear itself.
- It can run as a pseudo-random pattern generator that drives the logic downstream.
- It can compact a stream of parallel responses into a signature.
- It can act as a serial scan chain.

In its test role, the scan chain loads a non-zero seed before pattern generation and unloads the finished signature afterwards.

The flip-flops are shared among all the roles. Pattern generation and signature compaction use one and the same next-state path. In pattern-generator mode, the parallel data is masked to zero before it enters that path, which reduces the compactor to a plain shift register with external feedback. The feedback is the XOR of the register bits selected by a tap-mask parameter, and it enters at bit 0.

Top module: `bist_obs_reg`

## Requirements
- R1: While `rst_n` is low the register is held at all zeros, so `par_q` and `scan_out` read 0.
- R2: With `{ctl_hi,ctl_lo}` = 2'b11, `par_q` equals the value `par_in` had at the previous rising edge.
- R3: With `{ctl_hi,ctl_lo}` = 2'b01, the register becomes all zeros at the next rising edge, whatever `par_in` holds.
- R4: With `{ctl_hi,ctl_lo}` = 2'b00, each edge moves bit i-1 into bit i and loads `scan_in` into bit 0.
- R5: `scan_out` always shows bit WIDTH-1 of the register. Shifting WIDTH times in scan mode therefore unloads the stored word most significant bit first.
- R6: With `{ctl_hi,ctl_lo}` = 2'b10 and `gen_sel` = 1, the next state is the previous state shifted up by one bit, with the feedback bit in bit 0. `par_in` has no effect.
- R7: The default 8-bit instance (taps 8'hB8) is seeded non-zero and run in pattern-generator mode. It visits 255 distinct non-zero states and then returns to its seed.
- R8: With `{ctl_hi,ctl_lo}` = 2'b10 and `gen_sel` = 0, the next bit 0 is `par_in[0]` XOR feedback. For i > 0, the next bit i is `par_in[i]` XOR the previous bit i-1.
- R9: The feedback is the XOR of the register bits whose positions are set in `TAPS`, and `TAPS` must have bit WIDTH-1 set. An all-zero register in pattern-generator mode therefore stays all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_hi | input | 1 | Mode select, upper bit |
| ctl_lo | input | 1 | Mode select, lower bit |
| gen_sel | input | 1 | In test mode: 1 selects pattern generation, 0 selects signature compaction |
| par_in | input | WIDTH | Parallel data / response input |
| scan_in | input | 1 | Serial input into bit 0 |
| par_q | output | WIDTH | Register contents |
| scan_out | output | 1 | Serial output, bit WIDTH-1 |

## Verification
The hardest state to reach is the full pattern-generator cycle. It requires an arbitrary non-zero seed, and the only way to load one from the ports is the scan chain. The bench therefore shifts a seed in serially, switches to pattern mode, and then steps 255 cycles. At every step it records the states seen so far, to prove that no state repeats before the seed returns. Signature mode is checked in the same way: a known starting word is scanned in, a varied response sequence is compacted, and the result is scanned back out through `scan_out`.

// File: rtl/bist_obs_pkg.sv
package bist_obs_pkg;

   typedef enum logic [2:0] {
      OBS_SYSTEM = 3'd0,
      OBS_CLEAR  = 3'd1,
      OBS_PATGEN = 3'd2,
      OBS_SIGNAT = 3'd3,
      OBS_SCAN   = 3'd4
   } obs_mode_e;

   // {hi,lo} encodings of the two mode pins
   localparam logic [1:0] SEL_SYSTEM = 2'b11;
   localparam logic [1:0] SEL_CLEAR  = 2'b01;
   localparam logic [1:0] SEL_TEST   = 2'b10;
   localparam logic [1:0] SEL_SCAN   = 2'b00;

endpackage

// File: rtl/bist_obs_mode_dec.sv
module bist_obs_mode_dec
   import bist_obs_pkg::*;
(
   input  logic      ctl_hi,
   input  logic      ctl_lo,
   input  logic      gen_sel,
   output obs_mode_e mode
);

   always_comb begin
      unique case ({ctl_hi, ctl_lo})
         SEL_SYSTEM: mode = OBS_SYSTEM;
         SEL_CLEAR:  mode = OBS_CLEAR;
         SEL_TEST:   mode = gen_sel ? OBS_PATGEN : OBS_SIGNAT;
         default:    mode = OBS_SCAN;
      endcase
   end

endmodule

// File: rtl/bist_obs_feedback.sv
module bist_obs_feedback #(
   parameter int               WIDTH = 8,
   parameter logic [WIDTH-1:0] TAPS  = 'hB8
) (
   input  logic [WIDTH-1:0] state,
   output logic             fb
);

   logic [WIDTH-1:0] tapped;

   generate
      for (genvar k = 0; k < WIDTH; k++) begin : g_tap
         if (TAPS[k]) begin : g_on
            assign tapped[k] = state[k];
         end else begin : g_off
            assign tapped[k] = 1'b0;
         end
      end
   endgenerate

   assign fb = ^tapped;

endmodule

// File: rtl/bist_obs_reg.sv
module bist_obs_reg
   import bist_obs_pkg::*;
#(
   parameter int               WIDTH = 8,
   parameter logic [WIDTH-1:0] TAPS  = 'hB8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_hi,
   input  logic             ctl_lo,
   input  logic             gen_sel,
   input  logic [WIDTH-1:0] par_in,
   input  logic             scan_in,
   output logic [WIDTH-1:0] par_q,
   output logic             scan_out
);

   localparam int MSB = WIDTH - 1;

   // elaboration-time parameter checks
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bist_obs_reg: WIDTH must be at least 2");
      end
      if (!TAPS[MSB]) begin : g_bad_taps
         $error("bist_obs_reg: TAPS must include the top bit (R9)");
      end
   endgenerate

   obs_mode_e        mode;
   logic             fb;
   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] d;
   logic [WIDTH-1:0] z_eff;

   bist_obs_mode_dec u_dec (
      .ctl_hi  (ctl_hi),
      .ctl_lo  (ctl_lo),
      .gen_sel (gen_sel),
      .mode    (mode)
   );

   bist_obs_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
      .state (q),
      .fb    (fb)
   );

   // pattern generation = compaction with the parallel input masked off
   assign z_eff = (mode == OBS_PATGEN) ? '0 : par_in;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic comp_src;
         logic scan_src;
         if (i == 0) begin : g_head
            assign comp_src = fb;
            assign scan_src = scan_in;
         end else begin : g_body
            assign comp_src = q[i-1];
            assign scan_src = q[i-1];
         end

         always_comb begin
            unique case (mode)
               OBS_SYSTEM: d[i] = par_in[i];
               OBS_CLEAR:  d[i] = 1'b0;
               OBS_PATGEN,
               OBS_SIGNAT: d[i] = z_eff[i] ^ comp_src;
               default:    d[i] = scan_src;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

   assign par_q    = q;
   assign scan_out = q[MSB];

   // ---------------- assertions ----------------
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      ({ctl_hi, ctl_lo} == SEL_SYSTEM) |=> (par_q == $past(par_in)));

   a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ({ctl_hi, ctl_lo} == SEL_CLEAR) |=> (par_q == '0));

   a_r4_scan_shift: assert property (@(posedge clk) disable iff (!rst_n)
      ({ctl_hi, ctl_lo} == SEL_SCAN) |=>
         (par_q[0] == $past(scan_in)) && (par_q[MSB:1] == $past(par_q[MSB-1:0])));

   a_r6_gen_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (({ctl_hi, ctl_lo} == SEL_TEST) && gen_sel) |=>
         (par_q[MSB:1] == $past(par_q[MSB-1:0])));

   a_r9_zero_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (({ctl_hi, ctl_lo} == SEL_TEST) && gen_sel && (par_q == '0)) |=> (par_q == '0));

endmodule

// File: tb/bist_obs_reg_bench.sv
module bist_obs_reg_bench;

   localparam int         W    = 8;
   localparam logic [7:0] TAPS = 8'hB8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctl_hi = 1'b1, ctl_lo = 1'b1, gen_sel = 1'b0, scan_in = 1'b0;
   logic [W-1:0] par_in = '0;
   logic [W-1:0] par_q;
   logic         scan_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   bist_obs_reg #(.WIDTH(W), .TAPS(TAPS)) u_bist_obs_reg (
      .clk(clk), .rst_n(rst_n), .ctl_hi(ctl_hi), .ctl_lo(ctl_lo),
      .gen_sel(gen_sel), .par_in(par_in), .scan_in(scan_in),
      .par_q(par_q), .scan_out(scan_out)
   );

   function automatic logic [W-1:0] step(input logic [W-1:0] s, input logic [W-1:0] z);
      return {s[W-2:0], ^(s & TAPS)} ^ z;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_mode(input logic [1:0] sel, input logic g);
      {ctl_hi, ctl_lo} = sel;
      gen_sel = g;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // loads in_val MSB first, returns previous contents seen on scan_out
   task automatic scan_xfer(input logic [W-1:0] in_val, output logic [W-1:0] out_val);
      set_mode(2'b00, 1'b0);
      for (int i = W - 1; i >= 0; i--) begin
         scan_in = in_val[i];
         out_val[i] = scan_out;
         tick();
      end
   endtask

   task automatic t_reset();
      check("R1 par_q", par_q, '0);
      check("R1 scan_out", {7'b0, scan_out}, '0);
   endtask

   task automatic t_capture();
      set_mode(2'b11, 1'b0);
      par_in = 8'hA5; tick();
      check("R2 capture A5", par_q, 8'hA5);
      par_in = 8'h3C; tick();
      check("R2 capture 3C", par_q, 8'h3C);
      check("R5 scan_out msb", {7'b0, scan_out}, 8'h00);
      par_in = 8'h81; tick();
      check("R5 scan_out msb set", {7'b0, scan_out}, 8'h01);
   endtask

   task automatic t_clear();
      set_mode(2'b01, 1'b1);
      par_in = 8'hFF; tick();
      check("R3 clear", par_q, '0);
   endtask

   task automatic t_scan();
      logic [W-1:0] got;
      scan_xfer(8'hC9, got);
      check("R4 scan load", par_q, 8'hC9);
      scan_xfer(8'h17, got);
      check("R5 scan unload", got, 8'hC9);
      check("R4 scan load 2", par_q, 8'h17);
   endtask

   task automatic t_patgen();
      logic [W-1:0] exp;
      exp = par_q;
      set_mode(2'b10, 1'b1);
      for (int k = 0; k < 4; k++) begin
         par_in = 8'h5A ^ 8'(k * 37);
         exp = step(exp, '0);
         tick();
         check("R6 patgen ignores par_in", par_q, exp);
      end
   endtask

   task automatic t_period();
      logic [W-1:0] got;
      logic [W-1:0] seed;
      logic [W-1:0] exp;
      bit seen [256];
      bit ok;
      seed = 8'h01;
      scan_xfer(seed, got);
      set_mode(2'b10, 1'b1);
      par_in = 8'hFF;
      for (int k = 0; k < 256; k++) seen[k] = 1'b0;
      seen[seed] = 1'b1;
      ok = 1'b1;
      exp = seed;
      for (int k = 1; k < 255; k++) begin
         tick();
         exp = step(exp, '0);
         if (par_q == '0 || seen[par_q] || par_q !== exp) ok = 1'b0;
         seen[par_q] = 1'b1;
      end
      check("R7 255 distinct states", {7'b0, ok}, 8'h01);
      tick();
      check("R7 returns to seed", par_q, seed);
   endtask

   task automatic t_signature();
      logic [W-1:0] got;
      logic [W-1:0] exp;
      scan_xfer(8'h6E, got);
      exp = 8'h6E;
      set_mode(2'b10, 1'b0);
      for (int k = 0; k < 10; k++) begin
         par_in = 8'(k * 29 + 3);
         exp = step(exp, par_in);
         tick();
      end
      check("R8 signature", par_q, exp);
      scan_xfer(8'h00, got);
      check("R8 R5 signature unload", got, exp);
   endtask

   task automatic t_zero_lock();
      set_mode(2'b01, 1'b0); tick();
      set_mode(2'b10, 1'b1);
      par_in = 8'hFF;
      tick(); tick(); tick();
      check("R9 zero stays zero", par_q, '0);
   endtask

   task automatic t_reset_async();
      set_mode(2'b11, 1'b0);
      par_in = 8'hF0; tick();
      #1 rst_n = 1'b0;
      #1 check("R1 async reset", par_q, '0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_capture();
      t_clear();
      t_scan();
      t_patgen();
      t_period();
      t_signature();
      t_zero_lock();
      t_reset_async();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule